// File: doc/BRIEF.md
# Multi-Lane Pixel Frame Aggregator

This block gathers pixel words from a set of parallel lanes belonging to one sensor chip and turns them into a single framed output stream. Each lane writes into its own small synchronous FIFO. When a one-cycle trigger arrives, the block builds one frame. It first emits a header word, then reads a programmable number of words from every contributing lane, and finally emits a closing status word. Output uses a plain valid/ready handshake. When the consumer stalls, the lane FIFOs stop draining, so the backpressure reaches the lane inputs.

Per frame, a lane can be in one of three conditions. A lane marked for substitution produces a synthetic pattern and its FIFO is not read. A lane that is disabled and not substituted is skipped. Any other lane is read in turn. If an active lane stays empty longer than a programmable cycle limit, it is dropped for the rest of the frame and flagged. The block also counts completed frames, the last, largest and smallest payload sizes, rejected lane writes, triggers ignored while busy, and timeouts per lane.

Top module: `lane_aggregator`

## Requirements
- R1: After reset, out_valid and busy are 0, every counter and size_last and size_max are 0, and size_min is all ones.
- R2: A trigger seen while idle starts a frame. The first word has kind bits [31:30] = 01 and carries in bits [23:0] the number of frames completed before it. The last word has kind 10, comes with out_last high, and carries in bits [NUM_LANES-1:0] one flag per lane that timed out.
- R3: Payload words have kind 00, the lane index in bits [29:24] and the lane word in bits [DATA_W-1:0]. They are ordered by pixel index first and by ascending lane within each pixel index. There are words_req+1 pixel indices.
- R4: A lane whose bit is set in disable_mask, and not in enum_mask, contributes no words and its FIFO is left untouched. Its stored data appears unchanged in a later frame in which the lane is enabled.
- R5: A lane whose bit is set in enum_mask contributes one word per pixel index, whatever its disable bit. The data field holds the lane index in its top clog2(NUM_LANES) bits and the pixel index in the bits below. The lane's FIFO is not read.
- R6: If an active lane is still empty when its turn has waited more than timeout_limit cycles, the lane contributes nothing more in that frame, its flag in the closing word is set, and its timeout counter rises by 1.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. No word is lost or repeated.
- R8: On each completed frame, frame_count rises by 1 and size_last takes the payload word count. size_max and size_min track the largest and smallest payload count seen.
- R9: overflow_count rises by 1 in each cycle in which some lane writes while its FIFO is full, and that word is discarded.
- R10: A trigger arriving while a frame is being built increments drop_count and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_valid | input | NUM_LANES | Write strobe per lane |
| lane_data | input | NUM_LANES*DATA_W | Lane words, lane i at bits [i*DATA_W +: DATA_W] |
| trig | input | 1 | One-cycle frame start pulse |
| words_req | input | WORDS_W | Pixel indices per frame minus one |
| disable_mask | input | NUM_LANES | Lanes to skip |
| enum_mask | input | NUM_LANES | Lanes replaced by the synthetic pattern |
| timeout_limit | input | TMO_W | Allowed empty cycles per lane turn |
| out_ready | input | 1 | Consumer accepts the word |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the closing word of a frame |
| busy | output | 1 | A frame is being built |
| frame_count | output | CNT_W | Completed frames |
| size_last | output | SIZE_W | Payload words of the last frame |
| size_max | output | SIZE_W | Largest payload seen |
| size_min | output | SIZE_W | Smallest payload seen |
| overflow_count | output | CNT_W | Cycles with a rejected lane write |
| drop_count | output | CNT_W | Triggers ignored while busy |
| timeout_counts | output | NUM_LANES*CNT_W | Timeout count per lane, lane i at [i*CNT_W +: CNT_W] |

## Verification
A wrong lane pointer or pixel counter shows up in the very next payload word: its lane field or pattern value is off, or a word arrives in the wrong position relative to the header. A lost FIFO pointer update shows up one frame later, as stale or repeated data from that lane, so the stimulus deliberately leaves words behind in a disabled lane and reads them back afterwards. Faults in the counters and size statistics only become visible at the end of a frame, so they are compared after each trailer. Stall handling is exercised with a consumer that toggles its ready signal every cycle.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
   localparam int OUT_W = 32;
   localparam int LANE_FLD_LSB = 24;
   localparam logic [1:0] KIND_DATA = 2'b00;
   localparam logic [1:0] KIND_HEAD = 2'b01;
   localparam logic [1:0] KIND_TAIL = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_HEAD,
      ST_BODY,
      ST_TAIL
   } bld_state_e;
endpackage

// File: rtl/aggr_lane_fifo.sv
module aggr_lane_fifo #(
   parameter int DATA_W = 19,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [AW:0]       fill;
   logic              do_push, do_pop;

   assign full    = (fill == (AW+1)'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/aggr_frame_seq.sv
module aggr_frame_seq
   import aggr_pkg::*;
#(
   parameter int NUM_LANES = 24,
   parameter int DATA_W    = 19,
   parameter int WORDS_W   = 12,
   parameter int TMO_W     = 16,
   parameter int CNT_W     = 16,
   parameter int SIZE_W    = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        trig,
   input  logic [WORDS_W-1:0]          words_req,
   input  logic [NUM_LANES-1:0]        disable_mask,
   input  logic [NUM_LANES-1:0]        enum_mask,
   input  logic [TMO_W-1:0]            timeout_limit,
   input  logic [NUM_LANES-1:0]        fifo_empty,
   input  logic [NUM_LANES*DATA_W-1:0] fifo_dout,
   input  logic                        out_ready,
   input  logic [CNT_W-1:0]            frame_no,
   output logic [NUM_LANES-1:0]        fifo_pop,
   output logic                        out_valid,
   output logic [OUT_W-1:0]            out_data,
   output logic                        out_last,
   output logic                        busy,
   output logic                        drop_pulse,
   output logic [NUM_LANES-1:0]        tmo_pulse,
   output logic                        frame_done,
   output logic [SIZE_W-1:0]           payload_cnt
);
   localparam int LANE_W = $clog2(NUM_LANES);

   bld_state_e           state;
   logic [LANE_W-1:0]    lane_idx;
   logic [WORDS_W-1:0]   pix, words_l;
   logic [TMO_W-1:0]     wait_cnt;
   logic [NUM_LANES-1:0] dis_l, enum_l, tmo_flags;

   logic              cur_enum, cur_skip, cur_empty, adv, tmo_hit, waiting;
   logic              last_lane, last_pix;
   logic [DATA_W-1:0] cur_word, pattern, sel_word;

   assign cur_enum  = enum_l[lane_idx];
   assign cur_skip  = dis_l[lane_idx] | tmo_flags[lane_idx];
   assign cur_empty = fifo_empty[lane_idx];
   assign cur_word  = fifo_dout[int'(lane_idx)*DATA_W +: DATA_W];
   assign last_lane = (lane_idx == LANE_W'(NUM_LANES-1));
   assign last_pix  = (pix == words_l);
   assign busy      = (state != ST_IDLE);

   always_comb begin
      pattern = DATA_W'(pix);
      pattern[DATA_W-1 -: LANE_W] = lane_idx;
   end

   assign sel_word = cur_enum ? pattern : cur_word;

   always_comb begin
      out_valid = 1'b0;
      out_last  = 1'b0;
      out_data  = '0;
      fifo_pop  = '0;
      adv       = 1'b0;
      tmo_hit   = 1'b0;
      waiting   = 1'b0;
      unique case (state)
         ST_HEAD: begin
            out_valid = 1'b1;
            out_data[OUT_W-1 -: 2] = KIND_HEAD;
            out_data[LANE_FLD_LSB-1:0] = LANE_FLD_LSB'(frame_no);
         end
         ST_BODY: begin
            out_data[OUT_W-1 -: 2] = KIND_DATA;
            out_data[LANE_FLD_LSB +: 6] = 6'(lane_idx);
            out_data[DATA_W-1:0] = sel_word;
            if (cur_enum) begin
               out_valid = 1'b1;
               adv       = out_ready;
            end else if (cur_skip) begin
               adv = 1'b1;
            end else if (!cur_empty) begin
               out_valid          = 1'b1;
               fifo_pop[lane_idx] = out_ready;
               adv                = out_ready;
            end else if (wait_cnt >= timeout_limit) begin
               tmo_hit = 1'b1;
               adv     = 1'b1;
            end else begin
               waiting = 1'b1;
            end
         end
         ST_TAIL: begin
            out_valid = 1'b1;
            out_last  = 1'b1;
            out_data[OUT_W-1 -: 2] = KIND_TAIL;
            out_data[LANE_FLD_LSB-1:0] = LANE_FLD_LSB'(tmo_flags);
         end
         default: ;
      endcase
   end

   assign drop_pulse = trig && busy;
   assign tmo_pulse  = tmo_hit ? (NUM_LANES'(1) << lane_idx) : '0;
   assign frame_done = (state == ST_TAIL) && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         lane_idx    <= '0;
         pix         <= '0;
         words_l     <= '0;
         wait_cnt    <= '0;
         dis_l       <= '0;
         enum_l      <= '0;
         tmo_flags   <= '0;
         payload_cnt <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (trig) begin
                  state       <= ST_HEAD;
                  lane_idx    <= '0;
                  pix         <= '0;
                  wait_cnt    <= '0;
                  words_l     <= words_req;
                  dis_l       <= disable_mask;
                  enum_l      <= enum_mask;
                  tmo_flags   <= '0;
                  payload_cnt <= '0;
               end
            end
            ST_HEAD: if (out_ready) state <= ST_BODY;
            ST_BODY: begin
               if (out_valid && out_ready) payload_cnt <= payload_cnt + 1'b1;
               if (tmo_hit) tmo_flags <= tmo_flags | tmo_pulse;
               if (adv)          wait_cnt <= '0;
               else if (waiting) wait_cnt <= wait_cnt + 1'b1;
               if (adv) begin
                  if (last_lane) begin
                     lane_idx <= '0;
                     if (last_pix) state <= ST_TAIL;
                     else          pix   <= pix + 1'b1;
                  end else begin
                     lane_idx <= lane_idx + 1'b1;
                  end
               end
            end
            ST_TAIL: if (out_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/aggr_frame_stats.sv
module aggr_frame_stats #(
   parameter int NUM_LANES = 24,
   parameter int CNT_W     = 16,
   parameter int SIZE_W    = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_done,
   input  logic [SIZE_W-1:0]          payload_cnt,
   input  logic                       drop_pulse,
   input  logic                       ovf_pulse,
   input  logic [NUM_LANES-1:0]       tmo_pulse,
   output logic [CNT_W-1:0]           frame_count,
   output logic [SIZE_W-1:0]          size_last,
   output logic [SIZE_W-1:0]          size_max,
   output logic [SIZE_W-1:0]          size_min,
   output logic [CNT_W-1:0]           overflow_count,
   output logic [CNT_W-1:0]           drop_count,
   output logic [NUM_LANES*CNT_W-1:0] timeout_counts
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_count    <= '0;
         size_last      <= '0;
         size_max       <= '0;
         size_min       <= '1;
         overflow_count <= '0;
         drop_count     <= '0;
      end else begin
         if (frame_done) begin
            frame_count <= frame_count + 1'b1;
            size_last   <= payload_cnt;
            if (payload_cnt > size_max) size_max <= payload_cnt;
            if (payload_cnt < size_min) size_min <= payload_cnt;
         end
         if (ovf_pulse)  overflow_count <= overflow_count + 1'b1;
         if (drop_pulse) drop_count     <= drop_count + 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_tmo
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= '0;
         else if (tmo_pulse[g]) cnt <= cnt + 1'b1;
      end
      assign timeout_counts[g*CNT_W +: CNT_W] = cnt;
   end
endmodule

// File: rtl/lane_aggregator.sv
module lane_aggregator
   import aggr_pkg::*;
#(
   parameter int NUM_LANES  = 24,
   parameter int DATA_W     = 19,
   parameter int FIFO_DEPTH = 16,
   parameter int WORDS_W    = 12,
   parameter int TMO_W      = 16,
   parameter int CNT_W      = 16,
   parameter int SIZE_W     = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        lane_valid,
   input  logic [NUM_LANES*DATA_W-1:0] lane_data,
   input  logic                        trig,
   input  logic [WORDS_W-1:0]          words_req,
   input  logic [NUM_LANES-1:0]        disable_mask,
   input  logic [NUM_LANES-1:0]        enum_mask,
   input  logic [TMO_W-1:0]            timeout_limit,
   input  logic                        out_ready,
   output logic                        out_valid,
   output logic [OUT_W-1:0]            out_data,
   output logic                        out_last,
   output logic                        busy,
   output logic [CNT_W-1:0]            frame_count,
   output logic [SIZE_W-1:0]           size_last,
   output logic [SIZE_W-1:0]           size_max,
   output logic [SIZE_W-1:0]           size_min,
   output logic [CNT_W-1:0]            overflow_count,
   output logic [CNT_W-1:0]            drop_count,
   output logic [NUM_LANES*CNT_W-1:0]  timeout_counts
);
   localparam int LANE_W = $clog2(NUM_LANES);

   if (NUM_LANES < 2 || NUM_LANES > LANE_FLD_LSB) begin : g_bad_lanes
      $error("NUM_LANES must lie in 2..24");
   end
   if (DATA_W > LANE_FLD_LSB || DATA_W <= LANE_W) begin : g_bad_width
      $error("DATA_W must exceed the lane index width and not exceed 24");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH-1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end

   logic [NUM_LANES-1:0]        fifo_empty, fifo_full, fifo_pop, tmo_pulse;
   logic [NUM_LANES*DATA_W-1:0] fifo_dout;
   logic                        drop_pulse, frame_done, ovf_pulse;
   logic [SIZE_W-1:0]           payload_cnt;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      aggr_lane_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (lane_valid[g]),
         .din   (lane_data[g*DATA_W +: DATA_W]),
         .pop   (fifo_pop[g]),
         .dout  (fifo_dout[g*DATA_W +: DATA_W]),
         .empty (fifo_empty[g]),
         .full  (fifo_full[g])
      );
   end

   assign ovf_pulse = |(lane_valid & fifo_full);

   aggr_frame_seq #(
      .NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .WORDS_W(WORDS_W),
      .TMO_W(TMO_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .trig          (trig),
      .words_req     (words_req),
      .disable_mask  (disable_mask),
      .enum_mask     (enum_mask),
      .timeout_limit (timeout_limit),
      .fifo_empty    (fifo_empty),
      .fifo_dout     (fifo_dout),
      .out_ready     (out_ready),
      .frame_no      (frame_count),
      .fifo_pop      (fifo_pop),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_last      (out_last),
      .busy          (busy),
      .drop_pulse    (drop_pulse),
      .tmo_pulse     (tmo_pulse),
      .frame_done    (frame_done),
      .payload_cnt   (payload_cnt)
   );

   aggr_frame_stats #(
      .NUM_LANES(NUM_LANES), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
   ) u_stats (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_done     (frame_done),
      .payload_cnt    (payload_cnt),
      .drop_pulse     (drop_pulse),
      .ovf_pulse      (ovf_pulse),
      .tmo_pulse      (tmo_pulse),
      .frame_count    (frame_count),
      .size_last      (size_last),
      .size_max       (size_max),
      .size_min       (size_min),
      .overflow_count (overflow_count),
      .drop_count     (drop_count),
      .timeout_counts (timeout_counts)
   );
endmodule

// File: rtl/lane_aggregator_checker.sv
module lane_aggregator_checker #(
   parameter int NUM_LANES = 24,
   parameter int CNT_W     = 16,
   parameter int SIZE_W    = 24
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 trig,
   input logic                 busy,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [31:0]          out_data,
   input logic                 out_last,
   input logic [NUM_LANES-1:0] lane_valid,
   input logic [CNT_W-1:0]     overflow_count,
   input logic [CNT_W-1:0]     drop_count,
   input logic [CNT_W-1:0]     frame_count,
   input logic [SIZE_W-1:0]    size_min,
   input logic [SIZE_W-1:0]    size_max
);
   assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   assert_header_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> out_valid && out_data[31:30] == 2'b01);

   assert_last_is_trailer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |-> out_data[31:30] == 2'b10);

   assert_busy_trigger_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trig && busy |=> drop_count == CNT_W'($past(drop_count) + 1'b1));

   assert_frame_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> frame_count == CNT_W'($past(frame_count) + 1'b1));

   assert_min_not_above_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_count != '0 |-> size_min <= size_max);

   assert_no_overflow_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid == '0 |=> $stable(overflow_count));
endmodule

bind lane_aggregator lane_aggregator_checker #(
   .NUM_LANES(NUM_LANES), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
) u_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .trig           (trig),
   .busy           (busy),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_data       (out_data),
   .out_last       (out_last),
   .lane_valid     (lane_valid),
   .overflow_count (overflow_count),
   .drop_count     (drop_count),
   .frame_count    (frame_count),
   .size_min       (size_min),
   .size_max       (size_max)
);

// File: tb/lane_aggregator_bench.sv
`timescale 1ns/1ps
module lane_aggregator_bench;
   localparam int NL    = 4;
   localparam int DW    = 19;
   localparam int DEPTH = 8;
   localparam int LW    = 2;
   localparam int CW    = 16;
   localparam int SW    = 16;

   // vector: [15:12] disable, [11:8] enumerate, [7:0] words_req
   localparam logic [15:0] VEC [4] = '{16'h0002, 16'h5003, 16'h2201, 16'h0900};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NL-1:0]    lane_valid = '0;
   logic [NL*DW-1:0] lane_data = '0;
   logic             trig = 1'b0;
   logic [7:0]       words_req = '0;
   logic [NL-1:0]    disable_mask = '0, enum_mask = '0;
   logic [7:0]       timeout_limit = 8'd20;
   logic             out_ready = 1'b1;
   logic             out_valid, out_last, busy;
   logic [31:0]      out_data;
   logic [CW-1:0]    frame_count, overflow_count, drop_count;
   logic [SW-1:0]    size_last, size_max, size_min;
   logic [NL*CW-1:0] timeout_counts;

   lane_aggregator #(
      .NUM_LANES(NL), .DATA_W(DW), .FIFO_DEPTH(DEPTH), .WORDS_W(8),
      .TMO_W(8), .CNT_W(CW), .SIZE_W(SW)
   ) u_lane_aggregator (
      .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
      .trig(trig), .words_req(words_req), .disable_mask(disable_mask),
      .enum_mask(enum_mask), .timeout_limit(timeout_limit), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .busy(busy),
      .frame_count(frame_count), .size_last(size_last), .size_max(size_max),
      .size_min(size_min), .overflow_count(overflow_count), .drop_count(drop_count),
      .timeout_counts(timeout_counts)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 1'b0;
   bit toggle_ready = 1'b0;

   logic [DW-1:0] mq [NL][$];
   int  ovf_exp = 0, frames_done = 0, serial = 0;
   int  tc_exp [NL];
   int  smax = 0, smin = 65535, slast = 0;
   logic [31:0] exp_w [64];
   logic [31:0] rx_w [64];
   int  exp_n = 0, rx_n = 0;
   bit  got_last = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   always @(posedge clk) begin
      #1;
      if (toggle_ready) out_ready = ~out_ready;
      else              out_ready = 1'b1;
   end

   always @(negedge clk) begin
      if (out_valid && out_ready) begin
         if (rx_n < 64) rx_w[rx_n] = out_data;
         rx_n++;
         if (out_last) got_last = 1'b1;
      end
   end

   task automatic push_word(input int l, input logic [DW-1:0] v);
      @(posedge clk); #1;
      lane_valid = '0;
      lane_valid[l] = 1'b1;
      lane_data[l*DW +: DW] = v;
      if (mq[l].size() < DEPTH) mq[l].push_back(v);
      else ovf_exp++;
      @(posedge clk); #1;
      lane_valid = '0;
   endtask

   task automatic build_expected(input logic [NL-1:0] dis, input logic [NL-1:0] en, input int wr);
      logic [NL-1:0] dead = '0;
      exp_n = 0;
      exp_w[exp_n++] = {2'b01, 6'd0, 24'(frames_done)};
      for (int p = 0; p <= wr; p++) begin
         for (int l = 0; l < NL; l++) begin
            if (en[l]) begin
               exp_w[exp_n++] = {2'b00, 6'(l), 5'd0, DW'((l << (DW-LW)) | p)};
            end else if (!dis[l] && !dead[l]) begin
               if (mq[l].size() == 0) begin
                  dead[l] = 1'b1;
                  tc_exp[l]++;
               end else begin
                  exp_w[exp_n++] = {2'b00, 6'(l), 5'd0, mq[l].pop_front()};
               end
            end
         end
      end
      exp_w[exp_n++] = {2'b10, 6'd0, 24'(dead)};
   endtask

   task automatic run_frame(input string tag, input bit dup_trig);
      int mism;
      rx_n = 0;
      got_last = 1'b0;
      @(posedge clk); #1 trig = 1'b1;
      @(posedge clk); #1 trig = 1'b0;
      if (dup_trig) begin
         @(posedge clk); #1 trig = 1'b1;
         @(posedge clk); #1 trig = 1'b0;
      end
      while (!got_last) @(posedge clk);
      @(posedge clk); #1;
      mism = 0;
      for (int k = 0; k < exp_n; k++)
         if (k >= rx_n || k >= 64 || rx_w[k] !== exp_w[k]) mism++;
      chk({tag, " word count"}, rx_n, exp_n);
      chk({tag, " mismatched words"}, mism, 0);
      frames_done++;
      slast = exp_n - 2;
      if (slast > smax) smax = slast;
      if (slast < smin) smin = slast;
   endtask

   initial begin
      for (int l = 0; l < NL; l++) tc_exp[l] = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 out_valid", out_valid, 0);
      chk("R1 busy", busy, 0);
      chk("R1 frame_count", frame_count, 0);
      chk("R1 size_min", size_min, 16'hFFFF);
      chk("R1 size_max", size_max, 0);
      chk("R1 overflow_count", overflow_count, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      for (int i = 0; i < 4; i++) begin
         logic [NL-1:0] dis, en;
         int wr;
         dis = VEC[i][15:12];
         en  = VEC[i][11:8];
         wr  = int'(VEC[i][7:0]);
         // R4: leave a word in disabled lane 0; it must reappear in vector 2
         if (i == 1) push_word(0, DW'(19'h5A5A5));
         for (int l = 0; l < NL; l++)
            if (!en[l] && !dis[l])
               for (int k = 0; k <= wr; k++) push_word(l, DW'((l << 12) | serial++));
         disable_mask = dis;
         enum_mask = en;
         words_req = 8'(wr);
         toggle_ready = (i == 2);
         build_expected(dis, en, wr);
         run_frame($sformatf("R2 R3 R4 R5 vector%0d", i), 1'b0);
         if (i == 2) chk("R7 toggled ready frame size", size_last, SW'(slast));
         toggle_ready = 1'b0;
      end

      chk("R8 frame_count", frame_count, 4);
      chk("R8 size_last", size_last, SW'(slast));
      chk("R8 size_max", size_max, SW'(smax));
      chk("R8 size_min", size_min, SW'(smin));
      chk("R9 no overflow yet", overflow_count, 0);

      // R9: fill lane 0 completely, then one rejected write
      while (mq[0].size() < DEPTH) push_word(0, DW'(serial++));
      push_word(0, DW'(19'h7FFFF));
      chk("R9 overflow_count", overflow_count, CW'(ovf_exp));

      // R6 + R10: lanes 1..3 stay empty and time out; a second trigger is dropped
      disable_mask = '0;
      enum_mask = '0;
      words_req = 8'd7;
      timeout_limit = 8'd3;
      build_expected('0, '0, 7);
      run_frame("R6 timeout frame", 1'b1);
      chk("R6 trailer flags", rx_w[exp_n-1], {2'b10, 6'd0, 24'hE});
      for (int l = 0; l < NL; l++)
         chk($sformatf("R6 timeout count lane%0d", l), timeout_counts[l*CW +: CW], CW'(tc_exp[l]));
      chk("R10 drop_count", drop_count, 1);
      chk("R10 frame_count", frame_count, 5);
      chk("R10 idle after frame", busy, 0);
      chk("R8 size_last after timeout", size_last, SW'(slast));
      chk("R8 size_max final", size_max, SW'(smax));
      summary();
   end
endmodule